// File: doc/BRIEF.md
# Automatic Xon/Xoff flow controller

This block runs software flow control for one serial channel without any help from the host. It sits between a receiver, the receive FIFO and the transmitter. It watches the FIFO fill level with hysteresis. When the FIFO gets too full it asks the transmitter to insert an Xoff character. When the FIFO has drained far enough it asks for an Xon character.

The block also compares every received character against two programmable codes, one for Xon and one for Xoff. A matching character can stop or restart the local transmitter. The same character can be stored in the FIFO with its status or stripped from the stream. Every match sets a sticky interrupt flag that is cleared by a read strobe. When a character is stripped in block error mode, its status bits are kept in an accumulator.

The inserted character waits in a single request slot until the transmitter's next character boundary. At that boundary it goes ahead of any queued data character. Host commands to send Xon or Xoff by hand are honoured only while all automatic flow control is switched off.

Top module: `swfc_ctrl`

## Requirements
- R1: With `flow_mode[1]`=1 and the hysteresis state "Xon sent", a `fifo_level` of HI_MARK (12) or more sets `ins_req` on the next cycle, with `ins_char` equal to `xoff_code`, and moves the state to "Xoff sent".
- R2: In the "Xoff sent" state no further Xoff is requested, however full the FIFO is. A `fifo_level` of LO_MARK (8) or less requests an Xon (`ins_char` = `xon_code`) on the next cycle and moves the state back to "Xon sent".
- R3: After reset: `ins_req`=0, `tx_gate`=1, `fifo_push`=0, `flow_strip`=0, `err_acc`=0, `flow_irq_stat`=0, and the hysteresis state is "Xon sent". Clearing `flow_mode[1]` also returns the state to "Xon sent", so re-enabling it with a low FIFO level raises no request.
- R4: `ins_req` stays high until a cycle in which `tx_take` is high, and drops on the following cycle. If a newer request arrives while one is pending, the newer one replaces it.
- R5: With `flow_mode[0]`=1, a received `xoff_code` drives `tx_gate` low on the next cycle and a received `xon_code` drives it high. If both codes are equal, Xoff wins. With `flow_mode[0]`=0, `tx_gate` returns to 1 on the next cycle.
- R6: A pulse on `host_send_xon` or `host_send_xoff` requests that character only when `flow_mode`=00. For any other mode value the pulse is ignored and raises no `ins_req`.
- R7: One cycle after a received character: with `keep_flow_chars`=1, every character is pushed with its code and status. With `keep_flow_chars`=0, a character equal to either code gives `fifo_push`=0 and `flow_strip`=1, and all other characters are pushed.
- R8: When a character is stripped and `blk_err_mode`=1, its `rx_stat` is ORed into `err_acc`. When a character is stripped and `blk_err_mode`=0, its status is dropped. `err_clr` zeroes `err_acc`, but bits arriving in the same cycle are still kept.
- R9: Any received character equal to `xon_code` or `xoff_code` sets `flow_irq_stat` on the next cycle, whatever the values of `flow_mode` and `keep_flow_chars`. `flow_irq_rd` clears the flag, and a new match in the same cycle wins over the clear.
- R10: `flow_irq` is `flow_irq_stat` gated by `flow_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flow_mode | input | 2 | Bit 1: automatic receive-side Xoff/Xon; bit 0: automatic transmit gating |
| keep_flow_chars | input | 1 | 1 stores recognised flow characters, 0 strips them |
| blk_err_mode | input | 1 | 1 accumulates the status of stripped characters |
| xon_code | input | CW | Xon character code |
| xoff_code | input | CW | Xoff character code |
| flow_irq_en | input | 1 | Interrupt mask bit |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | CW | Received character |
| rx_stat | input | 3 | Received status {break, parity, framing} |
| fifo_level | input | LVL_W | Current receive FIFO fill level |
| host_send_xon | input | 1 | Manual Xon command pulse |
| host_send_xoff | input | 1 | Manual Xoff command pulse |
| tx_take | input | 1 | Transmitter at a character boundary, takes the insert if one is pending |
| err_clr | input | 1 | Clears the error accumulator |
| flow_irq_rd | input | 1 | Read strobe of the interrupt status |
| ins_req | output | 1 | Insert request to the transmitter |
| ins_char | output | CW | Character to insert |
| tx_gate | output | 1 | 1 lets the transmitter send data |
| fifo_push | output | 1 | Push to the receive FIFO |
| fifo_char | output | CW | Character to push |
| fifo_stat | output | 3 | Status to push |
| flow_strip | output | 1 | A flow character was stripped |
| err_acc | output | 3 | Accumulated status of stripped characters |
| flow_irq_stat | output | 1 | Sticky flow-character interrupt status |
| flow_irq | output | 1 | Masked interrupt |

## Verification
The fill level is stepped through a sequence: just under the high mark, at it, above it, back under it while still above the low mark, and then at the low mark. This shows whether the hysteresis fires once at each edge or repeats. A fill jump straight from the high mark to the low mark while an Xoff is still pending shows whether the pending slot is replaced. Directed character sequences set Xon, Xoff, ordinary data and equal codes against each mode bit, which separates transmit gating from the strip decision. A seeded random stream then mixes codes, status bits, read strobes and accumulator clears. Against a bench model it shows set-over-clear ordering and block-mode accumulation under overlapping events.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

   localparam int STAT_W = 3;

   typedef logic [STAT_W-1:0] rx_stat_t;

   typedef enum logic {
      INS_XON  = 1'b0,
      INS_XOFF = 1'b1
   } ins_kind_e;

   typedef struct packed {
      logic auto_rx;
      logic auto_tx;
   } flow_mode_t;

endpackage

// File: rtl/swfc_hyst.sv
// Receive-side hysteresis and the single insert-request slot.
module swfc_hyst
   import swfc_pkg::*;
#(
   parameter int LVL_W       = 5,
   parameter int HI_MARK     = 12,
   parameter int LO_MARK     = 8,
   parameter bit HOST_CMD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_rx,
   input  logic             host_ok,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             host_xon,
   input  logic             host_xoff,
   input  logic             tx_take,
   output logic             pend_valid,
   output ins_kind_e        pend_kind
);

   localparam logic [LVL_W-1:0] HI_L = LVL_W'(HI_MARK);
   localparam logic [LVL_W-1:0] LO_L = LVL_W'(LO_MARK);

   logic xoff_sent;
   logic auto_off, auto_on;
   logic man_off, man_on;
   logic new_req;
   ins_kind_e new_kind;

   // automatic requests
   always_comb begin
      auto_off = auto_rx && !xoff_sent && (fifo_level >= HI_L);
      auto_on  = auto_rx &&  xoff_sent && (fifo_level <= LO_L);
   end

   // manual command path, present only when enabled
   generate
      if (HOST_CMD_EN) begin : g_host
         always_comb begin
            man_off = host_ok && host_xoff;
            man_on  = host_ok && host_xon && !host_xoff;
         end
      end else begin : g_nohost
         logic unused_host;
         always_comb begin
            man_off     = 1'b0;
            man_on      = 1'b0;
            unused_host = host_ok ^ host_xon ^ host_xoff;
         end
      end
   endgenerate

   always_comb begin
      new_req  = auto_off || auto_on || man_off || man_on;
      new_kind = (auto_off || man_off) ? INS_XOFF : INS_XON;
   end

   // hysteresis state: 0 = Xon sent, 1 = Xoff sent
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xoff_sent <= 1'b0;
      end else if (!auto_rx) begin
         xoff_sent <= 1'b0;
      end else if (auto_off) begin
         xoff_sent <= 1'b1;
      end else if (auto_on) begin
         xoff_sent <= 1'b0;
      end
   end

   // request slot: newest request overwrites, transmitter boundary consumes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_kind  <= INS_XON;
      end else if (new_req) begin
         pend_valid <= 1'b1;
         pend_kind  <= new_kind;
      end else if (pend_valid && tx_take) begin
         pend_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/swfc_rxmatch.sv
// Character recognition, push/strip decision, status accumulation and
// the sticky interrupt flag.
module swfc_rxmatch
   import swfc_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [CW-1:0] rx_char,
   input  rx_stat_t      rx_stat,
   input  logic [CW-1:0] xon_code,
   input  logic [CW-1:0] xoff_code,
   input  logic          keep_flow_chars,
   input  logic          blk_err_mode,
   input  logic          err_clr,
   input  logic          irq_rd,
   output logic          hit_xon,
   output logic          hit_xoff,
   output logic          fifo_push,
   output logic [CW-1:0] fifo_char,
   output rx_stat_t      fifo_stat,
   output logic          flow_strip,
   output rx_stat_t      err_acc,
   output logic          irq_stat
);

   logic     recog;
   logic     strip_now;
   logic     push_now;
   rx_stat_t acc_add;

   always_comb begin
      hit_xon   = rx_valid && (rx_char == xon_code);
      hit_xoff  = rx_valid && (rx_char == xoff_code);
      recog     = hit_xon || hit_xoff;
      strip_now = recog && !keep_flow_chars;
      push_now  = rx_valid && !strip_now;
      acc_add   = (strip_now && blk_err_mode) ? rx_stat : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_push  <= 1'b0;
         fifo_char  <= '0;
         fifo_stat  <= '0;
         flow_strip <= 1'b0;
      end else begin
         fifo_push  <= push_now;
         flow_strip <= strip_now;
         if (push_now) begin
            fifo_char <= rx_char;
            fifo_stat <= rx_stat;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_acc <= '0;
      end else begin
         err_acc <= (err_clr ? '0 : err_acc) | acc_add;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_stat <= 1'b0;
      end else if (recog) begin
         irq_stat <= 1'b1;
      end else if (irq_rd) begin
         irq_stat <= 1'b0;
      end
   end

endmodule

// File: rtl/swfc_txgate.sv
// Transmit gating by received flow characters.
module swfc_txgate (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_tx,
   input  logic hit_xon,
   input  logic hit_xoff,
   output logic tx_gate
);

   logic halted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted <= 1'b0;
      end else if (!auto_tx) begin
         halted <= 1'b0;
      end else if (hit_xoff) begin
         halted <= 1'b1;
      end else if (hit_xon) begin
         halted <= 1'b0;
      end
   end

   assign tx_gate = !halted;

endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
   import swfc_pkg::*;
#(
   parameter int CW          = 8,
   parameter int FIFO_DEPTH  = 16,
   parameter int HI_MARK     = 12,
   parameter int LO_MARK     = 8,
   parameter bit HOST_CMD_EN = 1'b1,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           flow_mode,
   input  logic                 keep_flow_chars,
   input  logic                 blk_err_mode,
   input  logic [CW-1:0]        xon_code,
   input  logic [CW-1:0]        xoff_code,
   input  logic                 flow_irq_en,
   input  logic                 rx_valid,
   input  logic [CW-1:0]        rx_char,
   input  logic [STAT_W-1:0]    rx_stat,
   input  logic [LVL_W-1:0]     fifo_level,
   input  logic                 host_send_xon,
   input  logic                 host_send_xoff,
   input  logic                 tx_take,
   input  logic                 err_clr,
   input  logic                 flow_irq_rd,
   output logic                 ins_req,
   output logic [CW-1:0]        ins_char,
   output logic                 tx_gate,
   output logic                 fifo_push,
   output logic [CW-1:0]        fifo_char,
   output logic [STAT_W-1:0]    fifo_stat,
   output logic                 flow_strip,
   output logic [STAT_W-1:0]    err_acc,
   output logic                 flow_irq_stat,
   output logic                 flow_irq
);

   // elaboration-time parameter checks
   generate
      if (CW < 5 || CW > 9) begin : g_bad_cw
         $error("swfc_ctrl: CW out of range");
      end
      if (LO_MARK >= HI_MARK) begin : g_bad_marks
         $error("swfc_ctrl: LO_MARK must be below HI_MARK");
      end
      if (HI_MARK > FIFO_DEPTH) begin : g_bad_hi
         $error("swfc_ctrl: HI_MARK exceeds FIFO_DEPTH");
      end
   endgenerate

   flow_mode_t mode;
   ins_kind_e  pend_kind;
   logic       host_ok;
   logic       hit_xon, hit_xoff;

   assign mode    = flow_mode_t'(flow_mode);
   assign host_ok = !mode.auto_rx && !mode.auto_tx;

   swfc_hyst #(
      .LVL_W       (LVL_W),
      .HI_MARK     (HI_MARK),
      .LO_MARK     (LO_MARK),
      .HOST_CMD_EN (HOST_CMD_EN)
   ) u_hyst (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_rx    (mode.auto_rx),
      .host_ok    (host_ok),
      .fifo_level (fifo_level),
      .host_xon   (host_send_xon),
      .host_xoff  (host_send_xoff),
      .tx_take    (tx_take),
      .pend_valid (ins_req),
      .pend_kind  (pend_kind)
   );

   swfc_rxmatch #(
      .CW (CW)
   ) u_rxmatch (
      .clk             (clk),
      .rst_n           (rst_n),
      .rx_valid        (rx_valid),
      .rx_char         (rx_char),
      .rx_stat         (rx_stat),
      .xon_code        (xon_code),
      .xoff_code       (xoff_code),
      .keep_flow_chars (keep_flow_chars),
      .blk_err_mode    (blk_err_mode),
      .err_clr         (err_clr),
      .irq_rd          (flow_irq_rd),
      .hit_xon         (hit_xon),
      .hit_xoff        (hit_xoff),
      .fifo_push       (fifo_push),
      .fifo_char       (fifo_char),
      .fifo_stat       (fifo_stat),
      .flow_strip      (flow_strip),
      .err_acc         (err_acc),
      .irq_stat        (flow_irq_stat)
   );

   swfc_txgate u_txgate (
      .clk      (clk),
      .rst_n    (rst_n),
      .auto_tx  (mode.auto_tx),
      .hit_xon  (hit_xon),
      .hit_xoff (hit_xoff),
      .tx_gate  (tx_gate)
   );

   assign ins_char = (pend_kind == INS_XOFF) ? xoff_code : xon_code;
   assign flow_irq = flow_irq_stat && flow_irq_en;

endmodule

// File: rtl/swfc_ctrl_chk.sv
module swfc_ctrl_chk #(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    flow_mode,
   input logic          keep_flow_chars,
   input logic [CW-1:0] xon_code,
   input logic [CW-1:0] xoff_code,
   input logic          rx_valid,
   input logic [CW-1:0] rx_char,
   input logic          tx_take,
   input logic          flow_irq_rd,
   input logic          ins_req,
   input logic          tx_gate,
   input logic          fifo_push,
   input logic          flow_strip,
   input logic          flow_irq_stat
);

   logic is_flow;
   assign is_flow = rx_valid && (rx_char == xon_code || rx_char == xoff_code);

   // R9
   flow_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_flow |=> flow_irq_stat);

   // R9
   rd_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_irq_rd && !is_flow) |=> !flow_irq_stat);

   // R4
   ins_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !tx_take) |=> ins_req);

   // R5
   xoff_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode[0] && rx_valid && rx_char == xoff_code) |=> !tx_gate);

   // R7
   strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_flow && !keep_flow_chars) |=> (!fifo_push && flow_strip));

   // R6
   host_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode == 2'b01 && !ins_req) |=> !ins_req);

endmodule

bind swfc_ctrl swfc_ctrl_chk #(.CW(CW)) u_swfc_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .flow_mode       (flow_mode),
   .keep_flow_chars (keep_flow_chars),
   .xon_code        (xon_code),
   .xoff_code       (xoff_code),
   .rx_valid        (rx_valid),
   .rx_char         (rx_char),
   .tx_take         (tx_take),
   .flow_irq_rd     (flow_irq_rd),
   .ins_req         (ins_req),
   .tx_gate         (tx_gate),
   .fifo_push       (fifo_push),
   .flow_strip      (flow_strip),
   .flow_irq_stat   (flow_irq_stat)
);

// File: tb/swfc_ctrl_bench.sv
module swfc_ctrl_bench;

   localparam int CW    = 8;
   localparam int LVL_W = 5;
   localparam logic [7:0] XON  = 8'h11;
   localparam logic [7:0] XOFF = 8'h13;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    flow_mode;
   logic          keep_flow_chars, blk_err_mode, flow_irq_en;
   logic [CW-1:0] xon_code, xoff_code;
   logic          rx_valid;
   logic [CW-1:0] rx_char;
   logic [2:0]    rx_stat;
   logic [LVL_W-1:0] fifo_level;
   logic          host_send_xon, host_send_xoff, tx_take, err_clr, flow_irq_rd;
   logic          ins_req, tx_gate, fifo_push, flow_strip, flow_irq_stat, flow_irq;
   logic [CW-1:0] ins_char, fifo_char;
   logic [2:0]    fifo_stat, err_acc;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   swfc_ctrl u_swfc_ctrl (
      .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode),
      .keep_flow_chars(keep_flow_chars), .blk_err_mode(blk_err_mode),
      .xon_code(xon_code), .xoff_code(xoff_code), .flow_irq_en(flow_irq_en),
      .rx_valid(rx_valid), .rx_char(rx_char), .rx_stat(rx_stat),
      .fifo_level(fifo_level), .host_send_xon(host_send_xon),
      .host_send_xoff(host_send_xoff), .tx_take(tx_take), .err_clr(err_clr),
      .flow_irq_rd(flow_irq_rd), .ins_req(ins_req), .ins_char(ins_char),
      .tx_gate(tx_gate), .fifo_push(fifo_push), .fifo_char(fifo_char),
      .fifo_stat(fifo_stat), .flow_strip(flow_strip), .err_acc(err_acc),
      .flow_irq_stat(flow_irq_stat), .flow_irq(flow_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rx_one(input logic [7:0] c, input logic [2:0] s);
      rx_valid = 1'b1; rx_char = c; rx_stat = s;
      tick();
      rx_valid = 1'b0;
   endtask

   task automatic take;
      tx_take = 1'b1;
      tick();
      tx_take = 1'b0;
   endtask

   // bench-side expectations for the random phase
   function automatic logic f_flow(input logic v, input logic [7:0] c);
      return v && (c == XON || c == XOFF);
   endfunction

   function automatic logic f_halt(input logic [1:0] m, input logic v,
                                   input logic [7:0] c, input logic prev);
      if (!m[0]) return 1'b0;
      if (v && c == XOFF) return 1'b1;
      if (v && c == XON) return 1'b0;
      return prev;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic m_irq, m_halt, e_strip, e_push, e_flow;
      logic [2:0] m_acc;
      void'($urandom(32'd2718));
      rst_n = 1'b0; flow_mode = 2'b00; keep_flow_chars = 1'b0; blk_err_mode = 1'b0;
      xon_code = XON; xoff_code = XOFF; flow_irq_en = 1'b0;
      rx_valid = 1'b0; rx_char = '0; rx_stat = '0; fifo_level = '0;
      host_send_xon = 1'b0; host_send_xoff = 1'b0; tx_take = 1'b0;
      err_clr = 1'b0; flow_irq_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R3 reset ins_req", ins_req, 0);
      chk("R3 reset tx_gate", tx_gate, 1);
      chk("R3 reset fifo_push", fifo_push, 0);
      chk("R3 reset flow_strip", flow_strip, 0);
      chk("R3 reset err_acc", err_acc, 0);
      chk("R3 reset irq_stat", flow_irq_stat, 0);
      @(negedge clk);

      // hysteresis
      flow_mode = 2'b10;
      fifo_level = 5'd11; tick();
      chk("R1 below high mark", ins_req, 0);
      fifo_level = 5'd12; tick();
      chk("R1 xoff request", ins_req, 1);
      chk("R1 xoff char", ins_char, XOFF);
      fifo_level = 5'd15; tick();
      chk("R4 held without take", ins_req, 1);
      take();
      chk("R4 cleared by take", ins_req, 0);
      fifo_level = 5'd13; tick();
      chk("R2 no repeated xoff", ins_req, 0);
      fifo_level = 5'd9; tick();
      chk("R2 above low mark", ins_req, 0);
      fifo_level = 5'd8; tick();
      chk("R2 xon request", ins_req, 1);
      chk("R2 xon char", ins_char, XON);
      take();
      chk("R2 xon taken", ins_req, 0);

      // replacement of a pending request
      fifo_level = 5'd12; tick();
      chk("R4 xoff pending", ins_char, XOFF);
      fifo_level = 5'd8; tick();
      chk("R4 replaced still pending", ins_req, 1);
      chk("R4 replaced by xon", ins_char, XON);
      take();
      chk("R4 replaced taken", ins_req, 0);

      // leaving automatic receive mode resets the state
      fifo_level = 5'd12; tick();
      take();
      flow_mode = 2'b00; tick();
      fifo_level = 5'd5; flow_mode = 2'b10; tick();
      chk("R3 state back to xon sent", ins_req, 0);

      // host commands
      flow_mode = 2'b00; fifo_level = 5'd0;
      host_send_xoff = 1'b1; tick(); host_send_xoff = 1'b0;
      chk("R6 host xoff honoured", ins_req, 1);
      chk("R6 host xoff char", ins_char, XOFF);
      take();
      flow_mode = 2'b01;
      host_send_xon = 1'b1; tick(); host_send_xon = 1'b0;
      chk("R6 host xon blocked mode 01", ins_req, 0);
      flow_mode = 2'b11; fifo_level = 5'd5;
      host_send_xoff = 1'b1; tick(); host_send_xoff = 1'b0;
      chk("R6 host xoff blocked mode 11", ins_req, 0);

      // transmit gating
      flow_mode = 2'b01; fifo_level = 5'd0;
      rx_one(XOFF, 3'b000);
      chk("R5 xoff halts", tx_gate, 0);
      rx_one(8'h41, 3'b000);
      chk("R5 data keeps halt", tx_gate, 0);
      rx_one(XON, 3'b000);
      chk("R5 xon resumes", tx_gate, 1);
      rx_one(XOFF, 3'b000);
      flow_mode = 2'b00; tick();
      chk("R5 mode off opens gate", tx_gate, 1);
      flow_mode = 2'b01; xon_code = XOFF;
      rx_one(XOFF, 3'b000);
      chk("R5 equal codes xoff wins", tx_gate, 0);
      xon_code = XON;
      rx_one(XON, 3'b000);
      chk("R5 resume after equal codes", tx_gate, 1);

      // push / strip
      flow_mode = 2'b00; keep_flow_chars = 1'b0;
      rx_one(XON, 3'b000);
      chk("R7 stripped no push", fifo_push, 0);
      chk("R7 stripped flag", flow_strip, 1);
      keep_flow_chars = 1'b1;
      rx_one(XOFF, 3'b010);
      chk("R7 kept push", fifo_push, 1);
      chk("R7 kept char", fifo_char, XOFF);
      chk("R7 kept stat", fifo_stat, 3'b010);
      chk("R7 kept no strip", flow_strip, 0);
      keep_flow_chars = 1'b0;
      rx_one(8'h41, 3'b001);
      chk("R7 data pushed", fifo_push, 1);
      chk("R7 data char", fifo_char, 8'h41);

      // block error accumulation
      err_clr = 1'b1; tick(); err_clr = 1'b0;
      blk_err_mode = 1'b0;
      rx_one(XOFF, 3'b101);
      chk("R8 char mode drops status", err_acc, 0);
      blk_err_mode = 1'b1;
      rx_one(XOFF, 3'b101);
      chk("R8 block mode keeps status", err_acc, 3'b101);
      err_clr = 1'b1; tick(); err_clr = 1'b0;
      chk("R8 clear", err_acc, 0);

      // interrupt
      flow_irq_rd = 1'b1; tick(); flow_irq_rd = 1'b0;
      chk("R9 read clears", flow_irq_stat, 0);
      flow_mode = 2'b00;
      flow_irq_rd = 1'b1; rx_one(XON, 3'b000); flow_irq_rd = 1'b0;
      chk("R9 set wins over read", flow_irq_stat, 1);
      flow_irq_en = 1'b0; #1;
      chk("R10 masked", flow_irq, 0);
      flow_irq_en = 1'b1; #1;
      chk("R10 unmasked", flow_irq, 1);
      @(negedge clk);

      // random phase: bring model to a known state
      flow_mode = 2'b00; fifo_level = '0;
      err_clr = 1'b1; flow_irq_rd = 1'b1; tick();
      err_clr = 1'b0; flow_irq_rd = 1'b0;
      m_irq = 1'b0; m_acc = 3'b000; m_halt = 1'b0;
      for (int i = 0; i < 400; i++) begin
         int r;
         flow_mode       = 2'($urandom);
         keep_flow_chars = 1'($urandom);
         blk_err_mode    = 1'($urandom);
         flow_irq_en     = 1'($urandom);
         flow_irq_rd     = ($urandom % 4) == 0;
         err_clr         = ($urandom % 6) == 0;
         rx_valid        = ($urandom % 3) != 0;
         rx_stat         = 3'($urandom);
         r = $urandom % 4;
         rx_char = (r == 0) ? XON : (r == 1) ? XOFF : 8'($urandom);
         e_flow  = f_flow(rx_valid, rx_char);
         e_strip = e_flow && !keep_flow_chars;
         e_push  = rx_valid && !e_strip;
         m_irq   = e_flow ? 1'b1 : (flow_irq_rd ? 1'b0 : m_irq);
         m_acc   = (err_clr ? 3'b000 : m_acc) | ((e_strip && blk_err_mode) ? rx_stat : 3'b000);
         m_halt  = f_halt(flow_mode, rx_valid, rx_char, m_halt);
         tick();
         chk("R7 random push", fifo_push, e_push);
         chk("R7 random strip", flow_strip, e_strip);
         if (e_push) begin
            chk("R7 random char", fifo_char, rx_char);
            chk("R7 random stat", fifo_stat, rx_stat);
         end
         chk("R8 random err_acc", err_acc, m_acc);
         chk("R9 random irq_stat", flow_irq_stat, m_irq);
         chk("R10 random irq", flow_irq, m_irq && flow_irq_en);
         chk("R5 random tx_gate", tx_gate, !m_halt);
      end
      rx_valid = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule